// File: doc/BRIEF.md
# CCD Binned Readout Sequencer

This block sequences the charge transfers needed to read one CCD through one output amplifier. A readout request starts it; it then emits, one per clock cycle, parallel-shift strobes that move the image one row toward the serial register, serial-shift strobes that move the serial register one column toward the amplifier, and sample strobes that mark the cycle in which the video chain should digitize a pixel. A keep flag marks which sampled pixels belong to the recorded image. The analog clock levels and the video chain itself lie outside the block.

A readout has three row phases, always in this order. First come prescan rows, which are serial transfer only. Next come image rows, each collecting `row_bin` parallel shifts. Last come overscan rows, each with `row_bin` parallel shifts and a full serial row. Every row runs the same serial pattern. Each output pixel takes `col_bin` serial shifts and then one sample. The row holds the prescan columns, then the imaging columns of one amplifier, then `ovr_cols` binned overscan pixels.

Binning factors are checked against the geometry before a readout starts. This keeps binned pixels from straddling the mid-row amplifier boundary and keeps the binned row count whole. A bad combination is refused and flagged.

Top module: `ccd_readout_seq`

## Requirements
- R1: A start request is refused when any of these holds: `col_bin` is 0; `row_bin` is 0; `img_cols` is 0; `img_rows` is 0; `pre_cols + img_cols` is not a multiple of `col_bin`; `img_rows` is not a multiple of `row_bin`. On refusal, `cfg_err` goes high in the cycle after the request, `busy` stays low and no strobe is issued. `cfg_err` stays high until the next accepted start, which clears it.
- R2: At most one of `par_shift`, `ser_shift`, `sample` and `done` is high in any cycle. Every cycle of an accepted readout, from the cycle after the start until `done`, carries exactly one strobe. `done` is a single-cycle pulse in the cycle after the final sample, and `busy` is low in the following cycle.
- R3: Exactly `pre_rows` prescan rows are read before any image row. They contain serial shifts and samples and no parallel shift, so the first strobe of a readout is `ser_shift` when `pre_rows` is nonzero and `par_shift` otherwise.
- R4: The image is read as `img_rows / row_bin` binned rows. Each begins with `row_bin` consecutive parallel shifts and is followed by its serial row.
- R5: A serial row consists of `(pre_cols + img_cols) / col_bin + ovr_cols` output pixels. Each output pixel is exactly `col_bin` consecutive serial shifts followed by one sample.
- R6: After the image, `ovr_rows` overscan rows are read. Each has `row_bin` parallel shifts and a full serial row. The total parallel shift count of a readout is therefore `img_rows + row_bin * ovr_rows`.
- R7: `pix_keep` is high only together with `sample`. A sample is classed by the raw column index of its first serial shift in the row (0-based): below `pre_cols` it is prescan, below `pre_cols + img_cols` it is imaging, and otherwise it is overscan. Samples in prescan rows and prescan samples are never kept. Imaging samples in image rows are always kept. All other samples, whether in an overscan column or an overscan row, are kept only when `keep_ovr` was set.
- R8: A start request while `busy` is high is ignored. Configuration inputs are captured at the accepted start, so changing them during a readout has no effect on it.
- R9: While reset is asserted and after it is released, all strobes, `pix_keep`, `busy`, `done` and `cfg_err` are low until a start request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Readout request, sampled when idle |
| pre_cols | input | CW | Prescan columns per row |
| img_cols | input | CW | Imaging columns read by this amplifier |
| img_rows | input | RW | Imaging rows |
| row_bin | input | BW | Rows summed per binned row |
| col_bin | input | BW | Columns summed per output pixel |
| ovr_cols | input | CW | Binned overscan pixels per row |
| ovr_rows | input | RW | Overscan rows per image |
| pre_rows | input | RW | Prescan rows before the image |
| keep_ovr | input | 1 | Mark overscan samples as kept |
| par_shift | output | 1 | Parallel (row) transfer strobe |
| ser_shift | output | 1 | Serial (column) transfer strobe |
| sample | output | 1 | Pixel sample strobe |
| pix_keep | output | 1 | Sampled pixel belongs to the stored image |
| busy | output | 1 | Readout in progress |
| done | output | 1 | One-cycle end-of-readout pulse |
| cfg_err | output | 1 | Last start request was refused |

## Verification
The closing sample of a row and the change of row phase fall in the same cycle. The sample that finishes the last prescan row or the last image row must both end the row and pick the next phase, which decides whether the following strobe is a parallel or a serial shift. The stimulus table includes geometries whose phases are one row long, zero rows long, or several rows long, so the phase change happens in every position. Each case is judged by comparing the counts of parallel shifts, serial shifts, samples and kept pixels, and the first strobe, against values worked out by hand from the requirements. A second coincidence is a fresh start request with new configuration arriving in the middle of a readout; it is provoked by rewriting the inputs and raising start mid-run, and is judged by the run still producing the counts of the original configuration.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [1:0] {PH_PRE = 2'd0, PH_IMG = 2'd1, PH_OVR = 2'd2} phase_e;
  typedef enum logic [1:0] {RG_PRE = 2'd0, RG_IMG = 2'd1, RG_OVR = 2'd2} region_e;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0, ST_PAR = 3'd1, ST_SER = 3'd2, ST_SMP = 3'd3, ST_DONE = 3'd4
  } state_e;

  // A length is binnable when the factor is nonzero and divides it evenly.
  function automatic logic bin_fit(input logic [31:0] len, input logic [31:0] factor);
    return (factor != 32'd0) && (len != 32'd0) && ((len % factor) == 32'd0);
  endfunction

  // Class of a binned pixel by the raw column of its first serial shift.
  function automatic region_e col_region(input logic [31:0] first_col,
                                         input logic [31:0] pre,
                                         input logic [31:0] img);
    if (first_col < pre) return RG_PRE;
    if (first_col < pre + img) return RG_IMG;
    return RG_OVR;
  endfunction

  function automatic logic keep_pixel(input phase_e ph, input region_e rg, input logic keep_ovr);
    if (ph == PH_PRE || rg == RG_PRE) return 1'b0;
    if (ph == PH_IMG && rg == RG_IMG) return 1'b1;
    return keep_ovr;
  endfunction

endpackage

// File: rtl/ccd_seq_cfg_chk.sv
module ccd_seq_cfg_chk #(
  parameter int CW = 12,
  parameter int RW = 13,
  parameter int BW = 4
) (
  input  logic [CW-1:0] pre_cols,
  input  logic [CW-1:0] img_cols,
  input  logic [RW-1:0] img_rows,
  input  logic [BW-1:0] row_bin,
  input  logic [BW-1:0] col_bin,
  output logic          cfg_ok
);
  import ccd_seq_pkg::*;

  logic col_ok, row_ok;

  always_comb begin
    col_ok = bin_fit(32'(pre_cols) + 32'(img_cols), 32'(col_bin)) && (img_cols != '0);
    row_ok = bin_fit(32'(img_rows), 32'(row_bin));
    cfg_ok = col_ok && row_ok;
  end

endmodule

// File: rtl/ccd_seq_col_trk.sv
module ccd_seq_col_trk #(
  parameter int CW = 12,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          row_clr,
  input  logic          ser_step,
  input  logic          smp_step,
  input  logic [CW-1:0] pre_cols,
  input  logic [CW-1:0] img_cols,
  input  logic [CW-1:0] ovr_cols,
  input  logic [BW-1:0] col_bin,
  input  logic          keep_ovr,
  input  ccd_seq_pkg::phase_e phase,
  output logic          last_shift,
  output logic          row_end,
  output logic          keep_now
);
  import ccd_seq_pkg::*;

  localparam int TW = CW + BW + 1;

  logic [TW-1:0] col_pos;
  logic [TW-1:0] bin_start;
  logic [BW-1:0] bin_cnt;
  logic [TW-1:0] row_len;
  region_e       region;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_pos   <= '0;
      bin_start <= '0;
      bin_cnt   <= '0;
    end else if (row_clr) begin
      col_pos   <= '0;
      bin_start <= '0;
      bin_cnt   <= '0;
    end else begin
      if (ser_step) begin
        col_pos <= col_pos + TW'(1);
        bin_cnt <= bin_cnt + BW'(1);
      end
      if (smp_step) begin
        bin_cnt   <= '0;
        bin_start <= col_pos;
      end
    end
  end

  always_comb begin
    row_len    = TW'(pre_cols) + TW'(img_cols) + TW'(ovr_cols) * TW'(col_bin);
    last_shift = (bin_cnt == col_bin - BW'(1));
    row_end    = (col_pos == row_len);
    region     = col_region(32'(bin_start), 32'(pre_cols), 32'(img_cols));
    keep_now   = keep_pixel(phase, region, keep_ovr);
  end

endmodule

// File: rtl/ccd_seq_row_trk.sv
module ccd_seq_row_trk #(
  parameter int RW = 13,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          load_pre,
  input  logic          row_done,
  input  logic [RW-1:0] pre_rows,
  input  logic [RW-1:0] img_rows,
  input  logic [RW-1:0] ovr_rows,
  input  logic [BW-1:0] row_bin,
  output ccd_seq_pkg::phase_e phase,
  output logic          last_row,
  output logic          final_row
);
  import ccd_seq_pkg::*;

  logic [RW-1:0] row_cnt;
  logic [RW-1:0] step;
  phase_e        next_ph;

  always_comb begin
    step      = (phase == PH_IMG) ? RW'(row_bin) : RW'(1);
    unique case (phase)
      PH_PRE:  last_row = (row_cnt + step == pre_rows);
      PH_IMG:  last_row = (row_cnt + step == img_rows);
      default: last_row = (row_cnt + step == ovr_rows);
    endcase
    next_ph   = (phase == PH_PRE) ? PH_IMG : PH_OVR;
    final_row = last_row && ((phase == PH_OVR) || (phase == PH_IMG && ovr_rows == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IMG;
      row_cnt <= '0;
    end else if (load) begin
      phase   <= load_pre ? PH_PRE : PH_IMG;
      row_cnt <= '0;
    end else if (row_done) begin
      if (last_row) begin
        phase   <= next_ph;
        row_cnt <= '0;
      end else begin
        row_cnt <= row_cnt + step;
      end
    end
  end

endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq #(
  parameter int CW = 12,
  parameter int RW = 13,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] pre_cols,
  input  logic [CW-1:0] img_cols,
  input  logic [RW-1:0] img_rows,
  input  logic [BW-1:0] row_bin,
  input  logic [BW-1:0] col_bin,
  input  logic [CW-1:0] ovr_cols,
  input  logic [RW-1:0] ovr_rows,
  input  logic [RW-1:0] pre_rows,
  input  logic          keep_ovr,
  output logic          par_shift,
  output logic          ser_shift,
  output logic          sample,
  output logic          pix_keep,
  output logic          busy,
  output logic          done,
  output logic          cfg_err
);
  import ccd_seq_pkg::*;

  state_e        state;
  logic [BW-1:0] p_cnt;

  // captured configuration
  logic [CW-1:0] c_pre, c_img, c_ocol;
  logic [RW-1:0] c_rows, c_orow, c_prow;
  logic [BW-1:0] c_rb, c_cb;
  logic          c_keep;

  // named internal events
  logic   cfg_ok, accept, row_fin, col_last, col_rend, keep_now;
  logic   row_last, row_final;
  phase_e row_phase;

  ccd_seq_cfg_chk #(.CW(CW), .RW(RW), .BW(BW)) cfg_i (
    .pre_cols(pre_cols), .img_cols(img_cols), .img_rows(img_rows),
    .row_bin(row_bin), .col_bin(col_bin), .cfg_ok(cfg_ok)
  );

  ccd_seq_col_trk #(.CW(CW), .BW(BW)) col_i (
    .clk(clk), .rst_n(rst_n), .row_clr(accept || row_fin),
    .ser_step(ser_shift), .smp_step(sample),
    .pre_cols(c_pre), .img_cols(c_img), .ovr_cols(c_ocol), .col_bin(c_cb),
    .keep_ovr(c_keep), .phase(row_phase),
    .last_shift(col_last), .row_end(col_rend), .keep_now(keep_now)
  );

  ccd_seq_row_trk #(.RW(RW), .BW(BW)) row_i (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_pre(pre_rows != '0),
    .row_done(row_fin), .pre_rows(c_prow), .img_rows(c_rows), .ovr_rows(c_orow),
    .row_bin(c_rb), .phase(row_phase), .last_row(row_last), .final_row(row_final)
  );

  always_comb begin
    par_shift = (state == ST_PAR);
    ser_shift = (state == ST_SER);
    sample    = (state == ST_SMP);
    done      = (state == ST_DONE);
    busy      = (state != ST_IDLE);
    pix_keep  = sample && keep_now;
    accept    = (state == ST_IDLE) && start && cfg_ok;
    row_fin   = sample && col_rend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {c_pre, c_img, c_ocol} <= '0;
      {c_rows, c_orow, c_prow} <= '0;
      {c_rb, c_cb, c_keep} <= '0;
    end else if (accept) begin
      c_pre  <= pre_cols;
      c_img  <= img_cols;
      c_ocol <= ovr_cols;
      c_rows <= img_rows;
      c_orow <= ovr_rows;
      c_prow <= pre_rows;
      c_rb   <= row_bin;
      c_cb   <= col_bin;
      c_keep <= keep_ovr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      p_cnt   <= '0;
      cfg_err <= 1'b0;
    end else begin
      p_cnt <= (state == ST_PAR) ? p_cnt + BW'(1) : '0;
      unique case (state)
        ST_IDLE: if (start) begin
          if (cfg_ok) begin
            cfg_err <= 1'b0;
            state   <= (pre_rows != '0) ? ST_SER : ST_PAR;
          end else begin
            cfg_err <= 1'b1;
          end
        end
        ST_PAR:  if (p_cnt == c_rb - BW'(1)) state <= ST_SER;
        ST_SER:  if (col_last) state <= ST_SMP;
        ST_SMP: begin
          if (!col_rend) state <= ST_SER;
          else if (row_final) state <= ST_DONE;
          else if (row_phase == PH_PRE && !row_last) state <= ST_SER;
          else state <= ST_PAR;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ccd_readout_seq_sva.sv
module ccd_readout_seq_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       par_shift,
  input logic       ser_shift,
  input logic       sample,
  input logic       pix_keep,
  input logic       busy,
  input logic       done,
  input logic       cfg_err,
  input logic [1:0] phase_q
);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({par_shift, ser_shift, sample, done})); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R2

  AST_DONE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(sample)); // R2

  AST_SAMPLE_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> $past(ser_shift)); // R5

  AST_KEEP_ONLY_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_keep |-> sample); // R7

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy); // R1

  AST_NO_PAR_IN_PRESCAN: assert property (@(posedge clk) disable iff (!rst_n)
    par_shift |-> (phase_q != 2'd0)); // R3

endmodule

bind ccd_readout_seq ccd_readout_seq_sva sva_i (
  .clk(clk), .rst_n(rst_n), .par_shift(par_shift), .ser_shift(ser_shift),
  .sample(sample), .pix_keep(pix_keep), .busy(busy), .done(done),
  .cfg_err(cfg_err), .phase_q(row_phase)
);

// File: tb/ccd_readout_seq_tb.sv
module ccd_readout_seq_tb_top;

  localparam int CW = 12;
  localparam int RW = 13;
  localparam int BW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] pre_cols = '0, img_cols = '0, ovr_cols = '0;
  logic [RW-1:0] img_rows = '0, ovr_rows = '0, pre_rows = '0;
  logic [BW-1:0] row_bin = '0, col_bin = '0;
  logic keep_ovr = 1'b0;
  logic par_shift, ser_shift, sample, pix_keep, busy, done, cfg_err;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ccd_readout_seq #(.CW(CW), .RW(RW), .BW(BW)) dut_i (.*);

  typedef struct packed {
    int pre; int img; int rows; int rb; int cb; int osc; int osr; int prr; int keep; int err;
    int e_par; int e_ser; int e_smp; int e_keep; int e_first;
  } vec_t;

  // first-strobe code: 1 = parallel shift, 2 = serial shift
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2, 4, 4, 2, 2, 1, 1, 1, 0, 0,   6, 32, 16,  4, 2},
    '{2, 4, 4, 2, 2, 1, 1, 1, 1, 0,   6, 32, 16,  9, 2},
    '{1, 3, 3, 1, 1, 0, 0, 0, 0, 0,   3, 12, 12,  9, 1},
    '{3, 5, 6, 3, 4, 2, 2, 2, 1, 0,  12, 96, 24, 12, 2},
    '{0, 4, 2, 2, 1, 0, 0, 0, 0, 0,   2,  4,  4,  4, 1},
    '{2, 6, 4, 1, 3, 0, 0, 0, 0, 1,   0,  0,  0,  0, 0},
    '{0, 4, 4, 3, 1, 0, 0, 0, 0, 1,   0,  0,  0,  0, 0},
    '{2, 2, 2, 1, 0, 0, 0, 0, 0, 1,   0,  0,  0,  0, 0}
  };

  int n_par, n_ser, n_smp, n_keep, n_cyc, first_ev;
  int ev [16];
  int ev_n;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    pre_cols = CW'(v.pre);  img_cols = CW'(v.img);  img_rows = RW'(v.rows);
    row_bin  = BW'(v.rb);   col_bin  = BW'(v.cb);   ovr_cols = CW'(v.osc);
    ovr_rows = RW'(v.osr);  pre_rows = RW'(v.prr);  keep_ovr = v.keep[0];
  endtask

  task automatic run(input vec_t v, input bit disturb);
    int n;
    int code;
    bit seen;
    n_par = 0; n_ser = 0; n_smp = 0; n_keep = 0; n_cyc = 0; first_ev = 0; ev_n = 0;
    apply(v);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    seen = 1'b0;
    n = 0;
    while (!seen && n < 5000) begin
      code = par_shift ? 1 : ser_shift ? 2 : sample ? 3 : done ? 4 : 0;
      if (n == 0) first_ev = code;
      if (ev_n < 16) begin ev[ev_n] = code; ev_n++; end
      if (par_shift) n_par++;
      if (ser_shift) n_ser++;
      if (sample) n_smp++;
      if (pix_keep) n_keep++;
      if (done) seen = 1'b1;
      else if (busy) n_cyc++;
      if (disturb && n == 5) begin apply(VECS[3]); start = 1'b1; end
      if (disturb && n == 6) start = 1'b0;
      n++;
      if (!seen) @(negedge clk);
    end
    chk("R2 done seen", int'(seen), 1);
  endtask

  task automatic run_err(input vec_t v);
    int strobes;
    apply(v);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R1 cfg_err raised", int'(cfg_err), 1);
    chk("R1 busy stays low", int'(busy), 0);
    strobes = 0;
    for (int k = 0; k < 4; k++) begin
      strobes += int'(par_shift) + int'(ser_shift) + int'(sample) + int'(done);
      @(negedge clk);
    end
    chk("R1 no strobes after refusal", strobes, 0);
    chk("R1 cfg_err held", int'(cfg_err), 1);
  endtask

  task automatic check_counts(input vec_t v, input string tag);
    chk({tag, " R4 R6 parallel count"}, n_par, v.e_par);
    chk({tag, " R5 serial count"}, n_ser, v.e_ser);
    chk({tag, " R5 sample count"}, n_smp, v.e_smp);
    chk({tag, " R7 kept count"}, n_keep, v.e_keep);
    chk({tag, " R2 one strobe per busy cycle"}, n_cyc, v.e_par + v.e_ser + v.e_smp);
    chk({tag, " R3 first strobe"}, first_ev, v.e_first);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9 outputs in reset", int'({par_shift, ser_shift, sample, pix_keep, busy, done, cfg_err}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 outputs after reset", int'({par_shift, ser_shift, sample, pix_keep, busy, done, cfg_err}), 0);

    // stimulus table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].err != 0) begin
        run_err(VECS[i]);
      end else begin
        run(VECS[i], 1'b0);
        check_counts(VECS[i], $sformatf("vec%0d", i));
        @(negedge clk);
        chk("R2 idle after done", int'({busy, done}), 0);
      end
    end

    // R8 and R1: mid-run start with new config is ignored; accepted start clears cfg_err
    run(VECS[0], 1'b1);
    check_counts(VECS[0], "R8 disturbed");
    chk("R1 cfg_err cleared by accepted start", int'(cfg_err), 0);
    @(negedge clk);

    // R5 R4: exact strobe order of a 2x1 binned single row
    run(VECS[4], 1'b0);
    begin
      int exp_seq [11] = '{1, 1, 2, 3, 2, 3, 2, 3, 2, 3, 4};
      for (int k = 0; k < 11; k++) chk($sformatf("R5 order slot %0d", k), ev[k], exp_seq[k]);
    end
    @(negedge clk);

    // R3: first strobe of a run with prescan rows is serial
    run(VECS[3], 1'b0);
    chk("R3 prescan run starts serial", first_ev, 2);
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule